// File: doc/BRIEF.md
# Iterative Integer Divider With Exception Causes

This block divides a 32-bit dividend by a 32-bit divisor and returns the quotient, in signed or unsigned mode. A one-cycle request pulse starts an operation. The quotient comes from a restoring shift-subtract loop that settles one quotient bit per clock. One more clock then restores the sign.

Before the loop starts, the block checks the request for three faults. A fault ends the request at once. The block then pulses an exception strobe with an 8-bit cause code. It pulses no result write, and the quotient output keeps its previous value.

The surrounding core tells the block whether the divide feature is fitted. The core uses the write enable to update its destination register. It sends the exception strobe and cause to its trap logic.

Top module: `div_exc_top`

## Requirements
- R1: With `sign_sel` low, the quotient is the unsigned floor of dividend over divisor.
- R2: With `sign_sel` high, operands and quotient are two's complement, and the quotient is truncated toward zero (for example -7 / 2 gives -3).
- R3: When `feat_on` is low at an accepted request, the block raises `exc_stb` with `exc_cause` = 8'h01 (unimplemented). It starts no division.
- R4: A zero divisor raises `exc_stb` with `exc_cause` = 8'h02 (division error), in both modes.
- R5: In signed mode, dividend 32'h8000_0000 over divisor 32'hFFFF_FFFF raises `exc_stb` with cause 8'h02. In unsigned mode the same operands give quotient 0.
- R6: The faults are checked in a fixed priority order: feature absent first (8'h01), then zero divisor, then signed overflow.
- R7: A request is accepted when `req` is high at a rising edge while `busy` is low. For a fault, `exc_stb` is high for exactly the one cycle after that edge. Otherwise `busy` is high from that edge until 33 edges later, after which `done` and `wr_en` are high for exactly one cycle.
- R8: A `req` pulse that arrives while `busy` is high is ignored. It raises no exception, it does not change the running result, and it does not move the completion cycle.
- R9: `wr_en` is high only together with `done`, and is never high while `exc_stb` is high. On an exception, `quotient` keeps its previous value.
- R10: After reset, `busy`, `done`, `wr_en` and `exc_stb` are low, and `quotient` and `exc_cause` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request pulse |
| sign_sel | input | 1 | 1 = signed division, 0 = unsigned |
| feat_on | input | 1 | Divide feature present |
| dividend | input | 32 | Dividend, sampled at acceptance |
| divisor | input | 32 | Divisor, sampled at acceptance |
| busy | output | 1 | Division in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Destination register write enable |
| quotient | output | 32 | Last quotient, held until the next completion |
| exc_stb | output | 1 | One-cycle exception pulse |
| exc_cause | output | 8 | Cause code of the last exception |

## Verification
Directed cases cover the following:
- Sign combinations: each pairing of negative and positive operands, which separates truncation toward zero from floor rounding.
- The most negative dividend: over 1 and over -1 in signed mode, and the same bits in unsigned mode, which separates the overflow fault from an ordinary large quotient.
- Fault priority: zero divisors with and without the feature flag, which expose the priority among the faults.

Random operands come in several forms, which exercise every quotient bit position of the loop:
- full-width divisors,
- divisors shifted down,
- tiny divisors,
- all-ones divisors.

A request pulsed in mid-run, with the feature flag low, shows whether a busy request leaks into the exception path or disturbs the result and its completion cycle.

// File: rtl/div_exc_pkg.sv
package div_exc_pkg;

  localparam int unsigned CAUSE_W = 8;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE   = 8'h00,
    CAUSE_UNIMPL = 8'h01,
    CAUSE_DIVERR = 8'h02
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dstate_e;

  // Priority encoder for faults: feature absent, then zero divisor, then overflow.
  function automatic cause_e pick_cause(input logic feat_absent,
                                        input logic zero_div,
                                        input logic sovf);
    if (feat_absent)   return CAUSE_UNIMPL;
    else if (zero_div) return CAUSE_DIVERR;
    else if (sovf)     return CAUSE_DIVERR;
    else               return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/div_exc_guard.sv
module div_exc_guard
  import div_exc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         feat_on,
  input  logic         sign_sel,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         zero_div,
  output logic         sovf,
  output logic         fault,
  output cause_e       cause
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_comb begin
    zero_div = (den == '0);
    sovf     = sign_sel && (num == MOST_NEG) && (den == ALL_ONES);
    cause    = pick_cause(!feat_on, zero_div, sovf);
    fault    = (cause != CAUSE_NONE);
  end

endmodule

// File: rtl/div_exc_iter.sv
module div_exc_iter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num_mag,
  input  logic [W-1:0] den_mag,
  output logic [W-1:0] q_mag,
  output logic         active,
  output logic         last_step
);

  localparam int unsigned CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  qsh_q;
  logic [W-1:0]  den_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic          take;

  // One restoring step: shift in the next dividend bit, try to subtract.
  function automatic logic [W:0] sub_try(input logic [W:0] s, input logic [W-1:0] d);
    return s - {1'b0, d};
  endfunction

  always_comb begin
    shifted = {rem_q, qsh_q[W-1]};
    trial   = sub_try(shifted, den_q);
    take    = !trial[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      qsh_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      rem_q <= '0;
      qsh_q <= num_mag;
      den_q <= den_mag;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      rem_q <= take ? trial[W-1:0] : shifted[W-1:0];
      qsh_q <= {qsh_q[W-2:0], take};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) act_q <= 1'b0;
    end
  end

  assign q_mag     = qsh_q;
  assign active    = act_q;
  assign last_step = act_q && (cnt_q == LAST);

endmodule

// File: rtl/div_exc_signfix.sv
module div_exc_signfix #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] mag,
  input  logic         negate,
  output logic [W-1:0] value
);

  function automatic logic [W-1:0] twos(input logic [W-1:0] x);
    return (~x) + 1'b1;
  endfunction

  assign value = negate ? twos(mag) : mag;

endmodule

// File: rtl/div_exc_top.sv
module div_exc_top
  import div_exc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                sign_sel,
  input  logic                feat_on,
  input  logic [W-1:0]        dividend,
  input  logic [W-1:0]        divisor,
  output logic                busy,
  output logic                done,
  output logic                wr_en,
  output logic [W-1:0]        quotient,
  output logic                exc_stb,
  output logic [CAUSE_W-1:0]  exc_cause
);

  dstate_e      st_q;
  logic         neg_q;
  logic [W-1:0] q_out_q;
  logic         done_q;
  logic         wr_q;
  logic         exc_q;
  cause_e       cause_q;

  // Named internal events used by the checker.
  logic         accept_w;
  logic         fault_w;
  logic         start_w;
  logic         finish_w;
  logic         zero_w;
  logic         sovf_w;
  cause_e       cause_w;

  logic [W-1:0] num_mag;
  logic [W-1:0] den_mag;
  logic [W-1:0] q_mag;
  logic [W-1:0] q_fixed;
  logic         iter_act;
  logic         iter_last;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
    return (sgn && x[W-1]) ? ((~x) + 1'b1) : x;
  endfunction

  div_exc_guard #(.W(W)) u_guard (
    .feat_on  (feat_on),
    .sign_sel (sign_sel),
    .num      (dividend),
    .den      (divisor),
    .zero_div (zero_w),
    .sovf     (sovf_w),
    .fault    (fault_w),
    .cause    (cause_w)
  );

  assign accept_w = req && (st_q == ST_IDLE);
  assign start_w  = accept_w && !fault_w;
  assign num_mag  = magnitude(dividend, sign_sel);
  assign den_mag  = magnitude(divisor, sign_sel);

  div_exc_iter #(.W(W)) u_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_w),
    .num_mag   (num_mag),
    .den_mag   (den_mag),
    .q_mag     (q_mag),
    .active    (iter_act),
    .last_step (iter_last)
  );

  div_exc_signfix #(.W(W)) u_fix (
    .mag    (q_mag),
    .negate (neg_q),
    .value  (q_fixed)
  );

  assign finish_w = (st_q == ST_FIX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      neg_q   <= 1'b0;
      q_out_q <= '0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      exc_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      exc_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept_w) begin
            if (fault_w) begin
              exc_q   <= 1'b1;
              cause_q <= cause_w;
            end else begin
              neg_q <= sign_sel && (dividend[W-1] ^ divisor[W-1]);
              st_q  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (iter_last) st_q <= ST_FIX;
        end
        ST_FIX: begin
          q_out_q <= q_fixed;
          done_q  <= 1'b1;
          wr_q    <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign wr_en     = wr_q;
  assign quotient  = q_out_q;
  assign exc_stb   = exc_q;
  assign exc_cause = cause_q;

endmodule

// File: rtl/div_exc_chk.sv
module div_exc_chk
  import div_exc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               feat_on,
  input logic               busy,
  input logic               done,
  input logic               wr_en,
  input logic [W-1:0]       quotient,
  input logic               exc_stb,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               accept_w,
  input logic               zero_w,
  input logic               sovf_w,
  input logic               start_w
);

  localparam int unsigned CW = $clog2(W) + 3;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_cnt <= '0;
    else if (start_w) run_cnt <= '0;
    else if (busy)    run_cnt <= run_cnt + 1'b1;
  end

  a_r3_unimpl: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !feat_on) |=> (exc_stb && exc_cause == CAUSE_UNIMPL && !busy));

  a_r4_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && feat_on && zero_w) |=> (exc_stb && exc_cause == CAUSE_DIVERR));

  a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && feat_on && sovf_w) |=> (exc_stb && exc_cause == CAUSE_DIVERR));

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CW'(W + 1)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> !exc_stb);

  a_r9_no_write_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_stb |-> (!wr_en && !done));

  a_r9_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  a_r9_hold_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_stb |-> $stable(quotient));

endmodule

bind div_exc_top div_exc_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .feat_on   (feat_on),
  .busy      (busy),
  .done      (done),
  .wr_en     (wr_en),
  .quotient  (quotient),
  .exc_stb   (exc_stb),
  .exc_cause (exc_cause),
  .accept_w  (accept_w),
  .zero_w    (zero_w),
  .sovf_w    (sovf_w),
  .start_w   (start_w)
);

// File: tb/test_div_exc_top.sv
`timescale 1ns/1ps
module test_div_exc_top;

  localparam int W = 32;
  localparam int LAT = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        sign_sel = 1'b0;
  logic        feat_on = 1'b1;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, wr_en, exc_stb;
  logic [31:0] quotient;
  logic [7:0]  exc_cause;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] last_q = '0;

  always #2 clk = ~clk;

  div_exc_top #(.W(W)) i_div_exc_top (
    .clk(clk), .rst_n(rst_n), .req(req), .sign_sel(sign_sel), .feat_on(feat_on),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .wr_en(wr_en), .quotient(quotient), .exc_stb(exc_stb), .exc_cause(exc_cause)
  );

  task automatic check(input string req_id, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req_id, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cause(input logic f, input logic s,
                                           input logic [31:0] a, input logic [31:0] b);
    if (!f) return 8'h01;
    if (b == 0) return 8'h02;
    if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 8'h02;
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_quot(input logic s, input logic [31:0] a,
                                           input logic [31:0] b);
    if (s) return 32'($signed(a) / $signed(b));
    return a / b;
  endfunction

  // Runs one request; optionally fires a stray request with feature low mid-run.
  task automatic run_op(input string rid, input logic s, input logic f,
                        input logic [31:0] a, input logic [31:0] b, input bit stray);
    logic [7:0] ec;
    int seen;
    ec = exp_cause(f, s, a, b);
    @(negedge clk);
    req = 1'b1; sign_sel = s; feat_on = f; dividend = a; divisor = b;
    @(negedge clk);
    req = 1'b0;
    if (ec != 8'h00) begin
      check(rid, "exc_stb", {31'b0, exc_stb}, 32'd1);
      check(rid, "exc_cause", {24'b0, exc_cause}, {24'b0, ec});
      check("R9", "wr_en on exc", {31'b0, wr_en}, 32'd0);
      check("R9", "quotient held", quotient, last_q);
      @(negedge clk);
      check("R7", "exc one cycle", {31'b0, exc_stb}, 32'd0);
      return;
    end
    check("R7", "busy after accept", {31'b0, busy}, 32'd1);
    check("R7", "no exc", {31'b0, exc_stb}, 32'd0);
    seen = 0;
    for (int m = 1; m <= LAT + 6; m++) begin
      if (stray && m == 5) begin
        req = 1'b1; feat_on = 1'b0; dividend = 32'h1234; divisor = 32'h0;
      end else if (stray && m == 6) begin
        req = 1'b0; feat_on = 1'b1;
      end
      @(negedge clk);
      if (stray && m == 5) check("R8", "no exc from busy req", {31'b0, exc_stb}, 32'd0);
      if (done) begin seen = m; break; end
    end
    check("R7", "done cycle", seen, LAT);
    check(rid, "quotient", quotient, exp_quot(s, a, b));
    check("R9", "wr_en with done", {31'b0, wr_en}, 32'd1);
    check("R7", "busy clear at done", {31'b0, busy}, 32'd0);
    last_q = exp_quot(s, a, b);
    @(negedge clk);
    check("R7", "done one cycle", {30'b0, done, wr_en}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    check("R10", "busy", {31'b0, busy}, 32'd0);
    check("R10", "done", {31'b0, done}, 32'd0);
    check("R10", "wr_en", {31'b0, wr_en}, 32'd0);
    check("R10", "exc_stb", {31'b0, exc_stb}, 32'd0);
    check("R10", "quotient", quotient, 32'd0);
    check("R10", "exc_cause", {24'b0, exc_cause}, 32'd0);
    rst_n = 1'b1;

    run_op("R1", 0, 1, 32'd100, 32'd7, 0);
    run_op("R1", 0, 1, 32'hFFFF_FFFF, 32'd1, 0);
    run_op("R1", 0, 1, 32'd5, 32'd9, 0);
    run_op("R2", 1, 1, 32'hFFFF_FFF9, 32'd2, 0);
    run_op("R2", 1, 1, 32'd7, 32'hFFFF_FFFE, 0);
    run_op("R2", 1, 1, 32'hFFFF_FFF8, 32'hFFFF_FFFE, 0);
    run_op("R2", 1, 1, 32'h8000_0000, 32'd1, 0);
    run_op("R5", 1, 1, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_op("R5", 0, 1, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_op("R4", 0, 1, 32'd42, 32'd0, 0);
    run_op("R4", 1, 1, 32'hFFFF_0000, 32'd0, 0);
    run_op("R3", 0, 0, 32'd42, 32'd3, 0);
    run_op("R6", 1, 0, 32'h8000_0000, 32'd0, 0);
    run_op("R6", 1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    run_op("R8", 1, 1, 32'hFFFF_FF00, 32'd3, 1);
    run_op("R8", 0, 1, 32'd1000, 32'd10, 1);

    for (int i = 0; i < 80; i++) begin
      logic [31:0] a, b;
      logic s, f;
      int sel;
      a = $urandom;
      sel = $urandom % 8;
      case (sel)
        0: b = 32'd0;
        1: b = $urandom % 16;
        2: b = 32'hFFFF_FFFF;
        default: b = $urandom >> ($urandom % 32);
      endcase
      s = 1'($urandom % 2);
      f = (($urandom % 10) != 0);
      run_op(s ? "R2" : "R1", s, f, a, b, (i % 11) == 3);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule